// File: doc/BRIEF.md
# Arcsine-Linearized Sampling Phase-Locked Loop

This block is a sampled-input digital phase-locked loop. An internal oscillator measures out each period by counting system-clock cycles, and when a period ends the block captures one value of a signed input stream. The magnitude of that value is normalized against a slowly decaying running peak, so that the normalized value never leaves the range 0 to 1. A 256-entry arcsine table turns it into a phase estimate in radians, and the sign of the sample is put back afterwards. That phase passes through a loop filter, selected at run time as a pure gain (first order) or a gain plus a saturating integrator (second order). The filter output, in clock cycles with ten fractional bits, is subtracted from the nominal period to set the length of the next oscillator period.

After a strobe, the block processes the captured sample in a short state sequence. WAIT idles until the oscillator period ends; on that event it captures the sample, updates the peak, starts the divider and moves to DIVIDE. DIVIDE holds for the eight restoring-division steps and moves to LOOKUP when the divider reports completion. LOOKUP registers the signed arcsine phase and moves to FILTER. FILTER updates the integrator, the correction and the period, then returns to WAIT. The nominal period must exceed twice the processing latency (about a dozen cycles), so that the new period is in force before the running period can end.

Top module: `asin_sample_pll`

## Requirements
- R1: After synchronous reset the period output equals the nominal period, the correction and phase outputs are zero, the strobe is low, and the first strobe appears exactly the nominal period of cycles after reset is released.
- R2: The strobe is high for exactly one cycle per captured sample, and the number of cycles between two strobes equals the period output computed from the sample taken at the first of them; the period output does not change in a strobe cycle.
- R3: The running peak starts at 2047 and, for each sample, becomes the larger of |x| and peak - (peak >> 8); the next two requirements use this updated peak.
- R4: The table index is floor(|x| * 255 / peak) and the phase output is round(asin(index/255) * 1024), negated when the sample's sign bit is set; a zero sample gives phase 0.
- R5: The phase output never leaves the range -1608 to +1608 (plus and minus pi/2 with ten fractional bits), a sample of -2048 included.
- R6: With order2_i low, the correction equals (G1 * phase) >>> 10 and the integrator is cleared.
- R7: With order2_i high, the integrator becomes integ + ((G2 * phase) >>> 10), limited to the range -ILIM to +ILIM, and the correction equals (G1 * phase) >>> 10 plus the new integrator value.
- R8: The period output equals NOM - (correction >>> 10), clamped to the range NOM/2 to 2*NOM.
- R9: Under a long run of same-signed samples in second-order mode, the integrator stops at +ILIM or -ILIM and never wraps to the opposite sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| order2_i | input | 1 | 1 selects the second-order filter, 0 the first-order gain |
| samp_i | input | XW | Signed input stream, two's complement |
| stb_o | output | 1 | One-cycle pulse for each captured sample |
| period_o | output | PERW | Oscillator period in force, in clock cycles |
| corr_o | output | CW | Signed filter correction, clock cycles with 10 fractional bits |
| phase_o | output | FRAC+3 | Signed phase estimate, radians with 10 fractional bits |

## Verification
The bench sweeps the whole signed input range in both filter orders. It works out every phase, correction and period from the arcsine formula and a model of the peak, so a divider that is off by one step, or a wrong rounding, shows up as a phase that misses by a few codes. Full-scale runs of both signs drive the integrator into its limits, where a design that wraps would flip the sign of the correction, and push the period against both clamps, where a missing clamp would produce strobe intervals shorter than NOM/2 or longer than 2*NOM. Repeated small samples after a large one exercise the peak decay: a design that kept the old peak, or decayed it the wrong way, would give a phase trail that does not climb as expected. The interval measured between strobes is compared with the period set by the previous sample, which catches a design that applies a correction one sample late.

// File: rtl/asp_pkg.sv
package asp_pkg;

    typedef enum logic [1:0] {
        ST_WAIT,
        ST_DIVIDE,
        ST_LOOKUP,
        ST_FILTER
    } asp_state_e;

    // Arcsine of idx/lmax scaled by 2^frac, rounded to nearest
    function automatic int asin_code(input int idx, input int lmax, input int frac);
        real r;
        r = $asin(real'(idx) / real'(lmax)) * real'(1 << frac);
        return $rtoi(r + 0.5);
    endfunction

endpackage

// File: rtl/asp_dco.sv
module asp_dco #(
    parameter int PERW = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PERW-1:0] per_i,
    output logic            tick_o,
    output logic            stb_o
);

    logic [PERW-1:0] cnt_q;
    logic [PERW:0]   cnt_nxt;

    assign cnt_nxt = {1'b0, cnt_q} + (PERW+1)'(1);
    assign tick_o  = cnt_nxt >= {1'b0, per_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            stb_o <= 1'b0;
        end else begin
            stb_o <= tick_o;
            cnt_q <= tick_o ? '0 : cnt_nxt[PERW-1:0];
        end
    end

endmodule

// File: rtl/asp_peak_div.sv
module asp_peak_div #(
    parameter int XW  = 12,
    parameter int LB  = 8,
    parameter int DSH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [XW-1:0] mag_i,
    output logic          done_o,
    output logic [LB-1:0] idx_o
);

    localparam int NW   = XW + LB;
    localparam int LMAX = (1 << LB) - 1;
    localparam int BCW  = $clog2(LB);

    logic [XW-1:0]  peak_q, peak_dec, peak_n;
    logic [NW-1:0]  rem_q, den_q, trial;
    logic [BCW-1:0] bit_q;
    logic           busy_q;

    assign peak_dec = peak_q - (peak_q >> DSH);
    assign peak_n   = (mag_i > peak_dec) ? mag_i : peak_dec;
    assign trial    = den_q << bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            peak_q <= XW'((1 << (XW-1)) - 1);
            rem_q  <= '0;
            den_q  <= '0;
            bit_q  <= '0;
            busy_q <= 1'b0;
            done_o <= 1'b0;
            idx_o  <= '0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                peak_q <= peak_n;
                den_q  <= NW'(peak_n);
                rem_q  <= NW'(mag_i) * NW'(LMAX);
                bit_q  <= BCW'(LB - 1);
                busy_q <= 1'b1;
                idx_o  <= '0;
            end else if (busy_q) begin
                if (rem_q >= trial) begin
                    rem_q        <= rem_q - trial;
                    idx_o[bit_q] <= 1'b1;
                end
                if (bit_q == '0) begin
                    busy_q <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    bit_q <= bit_q - BCW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/asp_asin_rom.sv
module asp_asin_rom
    import asp_pkg::*;
#(
    parameter int LB   = 8,
    parameter int FRAC = 10,
    parameter int PW   = FRAC + 3
) (
    input  logic [LB-1:0] idx_i,
    output logic [PW-1:0] mag_o
);

    localparam int DEPTH = 1 << LB;

    logic [PW-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam int CODE = asin_code(i, DEPTH - 1, FRAC);
        assign tbl[i] = PW'(CODE);
    end

    assign mag_o = tbl[idx_i];

endmodule

// File: rtl/asin_sample_pll.sv
module asin_sample_pll
    import asp_pkg::*;
#(
    parameter int XW   = 12,
    parameter int LB   = 8,
    parameter int FRAC = 10,
    parameter int DSH  = 8,
    parameter int NOM  = 125000,
    parameter int G1   = 1024,
    parameter int G2   = 64,
    parameter int ILIM = 1048576,
    parameter int CW   = 24,
    parameter int PERW = $clog2(2*NOM + 1),
    parameter int PW   = FRAC + 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 order2_i,
    input  logic signed [XW-1:0] samp_i,
    output logic                 stb_o,
    output logic [PERW-1:0]      period_o,
    output logic signed [CW-1:0] corr_o,
    output logic signed [PW-1:0] phase_o
);

    localparam int MW = 48;

    asp_state_e state_q, state_d;

    logic                 tick, start, div_done, x_neg_q;
    logic [XW-1:0]        mag_in;
    logic [LB-1:0]        idx;
    logic [PW-1:0]        rom_mag;
    logic signed [PW-1:0] rom_s;
    logic signed [CW-1:0] integ_q, integ_n, corr_n;
    logic [PERW-1:0]      per_n;

    logic signed [MW-1:0] p1, p2, prop, iinc, isum, isat, inxt, csum, pnum, pcl;

    assign mag_in = samp_i[XW-1] ? $unsigned(-samp_i) : $unsigned(samp_i);
    assign start  = tick && (state_q == ST_WAIT);
    assign rom_s  = $signed(rom_mag);

    asp_dco #(.PERW(PERW)) u_dco (
        .clk    (clk),
        .rst    (rst),
        .per_i  (period_o),
        .tick_o (tick),
        .stb_o  (stb_o)
    );

    asp_peak_div #(.XW(XW), .LB(LB), .DSH(DSH)) u_div (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .mag_i   (mag_in),
        .done_o  (div_done),
        .idx_o   (idx)
    );

    asp_asin_rom #(.LB(LB), .FRAC(FRAC), .PW(PW)) u_rom (
        .idx_i (idx),
        .mag_o (rom_mag)
    );

    // Loop filter and period arithmetic
    always_comb begin
        p1   = MW'(G1) * MW'(phase_o);
        p2   = MW'(G2) * MW'(phase_o);
        prop = p1 >>> FRAC;
        iinc = p2 >>> FRAC;
        isum = MW'(integ_q) + iinc;
        if (isum > MW'(ILIM))
            isat = MW'(ILIM);
        else if (isum < -MW'(ILIM))
            isat = -MW'(ILIM);
        else
            isat = isum;
        inxt = order2_i ? isat : '0;
        csum = prop + inxt;
        pnum = MW'(NOM) - (csum >>> FRAC);
        if (pnum < MW'(NOM / 2))
            pcl = MW'(NOM / 2);
        else if (pnum > MW'(2 * NOM))
            pcl = MW'(2 * NOM);
        else
            pcl = pnum;
        integ_n = CW'(inxt);
        corr_n  = CW'(csum);
        per_n   = PERW'(pcl);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:   if (tick)     state_d = ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_d = ST_LOOKUP;
            ST_LOOKUP:               state_d = ST_FILTER;
            ST_FILTER:               state_d = ST_WAIT;
            default:                 state_d = ST_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_WAIT;
        else
            state_q <= state_d;
    end

    // Output and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            x_neg_q  <= 1'b0;
            phase_o  <= '0;
            integ_q  <= '0;
            corr_o   <= '0;
            period_o <= PERW'(NOM);
        end else begin
            if (start)
                x_neg_q <= samp_i[XW-1];
            if (state_q == ST_LOOKUP)
                phase_o <= x_neg_q ? -rom_s : rom_s;
            if (state_q == ST_FILTER) begin
                integ_q  <= integ_n;
                corr_o   <= corr_n;
                period_o <= per_n;
            end
        end
    end

endmodule

// File: rtl/asp_chk.sv
module asp_chk
    import asp_pkg::*;
#(
    parameter int LB   = 8,
    parameter int FRAC = 10,
    parameter int NOM  = 125000,
    parameter int ILIM = 1048576,
    parameter int CW   = 24,
    parameter int PERW = 18,
    parameter int PW   = 13
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 stb_o,
    input logic [PERW-1:0]      period_o,
    input logic signed [CW-1:0] corr_o,
    input logic signed [PW-1:0] phase_o,
    input logic signed [CW-1:0] integ
);

    localparam int PHMAX = asin_code((1 << LB) - 1, (1 << LB) - 1, FRAC);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (period_o == PERW'(NOM) && corr_o == '0 && phase_o == '0 && !stb_o));

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        stb_o |=> !stb_o);

    // R2
    period_steady_chk: assert property (@(posedge clk) disable iff (rst)
        stb_o |-> $stable(period_o));

    // R5
    phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_o <= PHMAX) && (phase_o >= -PHMAX));

    // R8
    period_range_chk: assert property (@(posedge clk) disable iff (rst)
        (period_o >= PERW'(NOM / 2)) && (period_o <= PERW'(2 * NOM)));

    // R9
    integ_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (integ <= ILIM) && (integ >= -ILIM));

endmodule

bind asin_sample_pll asp_chk #(
    .LB   (LB),
    .FRAC (FRAC),
    .NOM  (NOM),
    .ILIM (ILIM),
    .CW   (CW),
    .PERW (PERW),
    .PW   (PW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .stb_o    (stb_o),
    .period_o (period_o),
    .corr_o   (corr_o),
    .phase_o  (phase_o),
    .integ    (integ_q)
);

// File: tb/sim_asin_sample_pll.sv
module sim_asin_sample_pll;

    localparam int XW   = 12;
    localparam int LB   = 8;
    localparam int FRAC = 10;
    localparam int DSH  = 8;
    localparam int NOM  = 40;
    localparam int G1   = 20480;
    localparam int G2   = 1024;
    localparam int ILIM = 20480;
    localparam int CW   = 24;
    localparam int PERW = $clog2(2*NOM + 1);
    localparam int PW   = FRAC + 3;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 order2 = 1'b0;
    logic signed [XW-1:0] samp = '0;
    logic                 stb;
    logic [PERW-1:0]      period;
    logic signed [CW-1:0] corr;
    logic signed [PW-1:0] phase;

    always #4 clk = ~clk;

    asin_sample_pll #(
        .XW(XW), .LB(LB), .FRAC(FRAC), .DSH(DSH), .NOM(NOM),
        .G1(G1), .G2(G2), .ILIM(ILIM), .CW(CW), .PERW(PERW), .PW(PW)
    ) u0 (
        .clk      (clk),
        .rst      (rst),
        .order2_i (order2),
        .samp_i   (samp),
        .stb_o    (stb),
        .period_o (period),
        .corr_o   (corr),
        .phase_o  (phase)
    );

    int     n_cmp = 0;
    int     n_bad = 0;
    bit     hung = 1'b0;
    bit     summarized = 1'b0;
    longint m_peak = 2047;
    longint m_integ = 0;
    int     cur_x = 0;

    task automatic summary();
        if (!summarized) begin
            summarized = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint asin_ref(input longint idx);
        return longint'($rtoi($asin(real'(idx) / 255.0) * 1024.0 + 0.5));
    endfunction

    // Reference arithmetic for one sample (R3, R4, R6, R7, R8)
    task automatic model(input int x, input bit ord,
                         output longint ph, output longint c, output longint p);
        longint mag, dec, idx, prop, ii, pn;
        mag = (x < 0) ? -x : x;
        dec = m_peak - (m_peak >>> 8);
        m_peak = (mag > dec) ? mag : dec;
        idx = (mag * 255) / m_peak;
        ph = asin_ref(idx);
        if (x < 0) ph = -ph;
        prop = (G1 * ph) >>> FRAC;
        if (ord) begin
            ii = m_integ + ((G2 * ph) >>> FRAC);
            if (ii > ILIM) ii = ILIM;
            if (ii < -ILIM) ii = -ILIM;
            m_integ = ii;
        end else begin
            m_integ = 0;
        end
        c = prop + m_integ;
        pn = NOM - (c >>> FRAC);
        if (pn < NOM / 2) pn = NOM / 2;
        if (pn > 2 * NOM) pn = 2 * NOM;
        p = pn;
    endtask

    task automatic wait_strobe(output int cyc);
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end while (!stb && cyc < 1000);
        if (!stb) begin
            hung = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R2 strobe missing: actual %0d expected <1000 cycles", cyc);
        end
    endtask

    // Called at a strobe: model the captured sample, drive the next one
    task automatic step(input string grp, input int xn, input bit ord);
        longint ph, c, p;
        int cyc;
        if (hung) return;
        order2 = ord;
        model(cur_x, ord, ph, c, p);
        samp = XW'(xn);
        cur_x = xn;
        wait_strobe(cyc);
        if (hung) return;
        chk({grp, "/R4"}, "phase", longint'(phase), ph);
        chk({grp, ord ? "/R7" : "/R6"}, "correction", longint'(corr), c);
        chk({grp, "/R8"}, "period", longint'(period), p);
        chk({grp, "/R2"}, "strobe interval", longint'(cyc), p);
    endtask

    initial begin
        int cyc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "period at reset", longint'(period), NOM);
        chk("R1", "correction at reset", longint'(corr), 0);
        chk("R1", "phase at reset", longint'(phase), 0);
        chk("R1", "strobe at reset", longint'(stb), 0);
        rst = 1'b0;
        wait_strobe(cyc);
        if (!hung) chk("R1", "first strobe delay", longint'(cyc), NOM);

        // First sample is zero: phase 0 (R4); then first-order sweep (R6)
        for (int x = -2048; x <= 2047; x += 61)
            step("R6", x, 1'b0);
        step("R4", 0, 1'b0);
        // Second-order sweep (R7)
        for (int x = 2047; x >= -2048; x -= 53)
            step("R7", x, 1'b1);
        // Most negative code, bound check (R5)
        step("R5", -2048, 1'b0);
        step("R5", 2047, 1'b0);
        // Peak decay with small repeated samples (R3)
        for (int k = 0; k < 24; k++)
            step("R3", 300, 1'b0);
        // Integrator saturation positive then negative, period clamps (R9, R8)
        for (int k = 0; k < 30; k++)
            step("R9", 2047, 1'b1);
        for (int k = 0; k < 40; k++)
            step("R9", -2048, 1'b1);
        // Back to first order: integrator cleared (R6)
        for (int k = 0; k < 4; k++)
            step("R6", 1500 - 700 * k, 1'b0);
        step("R6", 0, 1'b0);

        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!summarized) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule